// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block closes out one floating-point operation by folding the exceptions the operation raised into the status register. A single-cycle strobe presents the 5-bit raised-exception vector, the current status word and the current and next program counters. One cycle later the block presents the rewritten status word and the program-counter pair. It also presents either a one-cycle trap request or a one-cycle completion pulse.

The trap decision compares the raised vector against the trap-enable field of the status word. On a trap, only one exception is reported: the enabled, raised cause with the highest priority. The accrued history and the program counters are left alone, and the trap-type bit is set. With no trap, the whole raised vector becomes the current exceptions and is ORed into the accrued field, and execution steps forward by one instruction. An operation that raised nothing follows the no-trap path with an empty vector.

Top module: `fp_exc_recorder`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `status_o`, `pc_o` and `npc_o` read zero and `trap_o` and `ok_o` are low.
- R2: A trap is taken when the raised vector ANDed with the enable field (status bits 27:23) is non-zero. In the cycle after the strobe, `trap_o` is high for exactly one cycle on a trap. Otherwise `ok_o` is high for exactly one cycle instead. The two are never high together.
- R3: The exception bits use the same position in every 5-bit field: bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact. On a trap, the current field (status bits 4:0) holds exactly one bit: the highest-numbered bit of raised AND enabled.
- R4: Without a trap, the current field is loaded with the full raised vector, including raised causes whose enable is off.
- R5: Without a trap, the accrued field (status bits 9:5) becomes its old value ORed with the raised vector. On a trap, it keeps its old value.
- R6: On a trap, status bit 14 is set in the output word. Without a trap, bit 14 passes through from the input.
- R7: Without a trap, `pc_o` takes `npc_in` and `npc_o` takes `npc_in` plus 4, wrapping at the counter width. On a trap, `pc_o` and `npc_o` equal `pc_in` and `npc_in`.
- R8: An operation that raised nothing clears the current field. It leaves the accrued field unchanged and advances the program counters, even when every enable bit is set.
- R9: Cycles without a strobe leave `status_o`, `pc_o` and `npc_o` unchanged and keep `trap_o` and `ok_o` low.
- R10: Status bits outside the current field, the accrued field and bit 14 pass from `stat_in` to `status_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Single-cycle strobe that marks a completed operation |
| exc_raised | input | 5 | Exceptions raised by the operation |
| stat_in | input | STAT_W (32) | Status word before the update |
| pc_in | input | PC_W (64) | Program counter of the operation |
| npc_in | input | PC_W (64) | Next program counter |
| status_o | output | STAT_W (32) | Status word after the update |
| pc_o | output | PC_W (64) | Program counter after the update |
| npc_o | output | PC_W (64) | Next program counter after the update |
| trap_o | output | 1 | One-cycle trap request |
| ok_o | output | 1 | One-cycle completion pulse without a trap |

## Verification
The properties assume that `exc_raised`, `stat_in`, `pc_in` and `npc_in` are meaningful only in a cycle where `upd_valid` is high. They compare each registered output with the inputs sampled on the strobe one cycle earlier, so the inputs may change freely between strobes. The stimulus raises the strobe for exactly one clock and drops it before the outputs are sampled. It then keeps the strobe low for at least one more cycle, so that the pulse width and the hold behaviour are both observed.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    // Width of every exception field; bit order inside: 4 invalid .. 0 inexact
    localparam int EXC_W    = 5;
    // Field anchors inside the status word
    localparam int CUR_LSB  = 0;
    localparam int ACC_LSB  = 5;
    localparam int ENA_LSB  = 23;
    localparam int TTYP_BIT = 14;
    // Smallest status width that holds every field
    localparam int STAT_MIN = ENA_LSB + EXC_W;

    typedef logic [EXC_W-1:0] exc_vec_t;

    typedef enum logic [2:0] {
        EXC_NX = 3'd0,
        EXC_DZ = 3'd1,
        EXC_UF = 3'd2,
        EXC_OF = 3'd3,
        EXC_NV = 3'd4
    } exc_pos_e;

    typedef struct packed {
        logic     trap;
        exc_vec_t report;
    } exc_decision_t;

    function automatic exc_vec_t field_of(input logic [63:0] word, input int lsb);
        return word[lsb +: EXC_W];
    endfunction

endpackage

// File: rtl/fpx_trap_select.sv
module fpx_trap_select
    import fpx_pkg::*;
(
    input  exc_vec_t      raised,
    input  exc_vec_t      enables,
    output exc_decision_t decision
);

    exc_vec_t hit;
    exc_vec_t pick;

    assign hit = raised & enables;

    // Highest-numbered enabled cause wins; each bit is blocked by any above it
    for (genvar i = 0; i < EXC_W; i++) begin : g_pri
        if (i == EXC_W - 1) begin : g_top
            assign pick[i] = hit[i];
        end else begin : g_low
            assign pick[i] = hit[i] & ~(|hit[EXC_W-1:i+1]);
        end
    end

    always_comb begin
        decision.trap   = |hit;
        decision.report = decision.trap ? pick : raised;
    end

endmodule

// File: rtl/fpx_status_merge.sv
module fpx_status_merge
    import fpx_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic [STAT_W-1:0] stat_in,
    input  exc_decision_t     decision,
    output logic [STAT_W-1:0] stat_next
);

    always_comb begin
        stat_next = stat_in;
        stat_next[CUR_LSB +: EXC_W] = decision.report;
        if (decision.trap) begin
            stat_next[TTYP_BIT] = 1'b1;
        end else begin
            stat_next[ACC_LSB +: EXC_W] = stat_in[ACC_LSB +: EXC_W] | decision.report;
        end
    end

endmodule

// File: rtl/fpx_pc_step.sv
module fpx_pc_step #(
    parameter int PC_W    = 64,
    parameter int PC_STEP = 4
) (
    input  logic            advance,
    input  logic [PC_W-1:0] pc_cur,
    input  logic [PC_W-1:0] pc_nxt,
    output logic [PC_W-1:0] pc_cur_n,
    output logic [PC_W-1:0] pc_nxt_n
);

    localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

    always_comb begin
        if (advance) begin
            pc_cur_n = pc_nxt;
            pc_nxt_n = pc_nxt + STEP_V;
        end else begin
            pc_cur_n = pc_cur;
            pc_nxt_n = pc_nxt;
        end
    end

endmodule

// File: rtl/fp_exc_recorder.sv
module fp_exc_recorder
    import fpx_pkg::*;
#(
    parameter int STAT_W  = 32,
    parameter int PC_W    = 64,
    parameter int PC_STEP = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_valid,
    input  logic [4:0]        exc_raised,
    input  logic [STAT_W-1:0] stat_in,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [PC_W-1:0]   npc_in,
    output logic [STAT_W-1:0] status_o,
    output logic [PC_W-1:0]   pc_o,
    output logic [PC_W-1:0]   npc_o,
    output logic              trap_o,
    output logic              ok_o
);

    initial begin
        if (STAT_W < STAT_MIN) $error("STAT_W too small for the enable field");
    end

    exc_decision_t     dec;
    logic [STAT_W-1:0] stat_nx;
    logic [PC_W-1:0]   pc_nx;
    logic [PC_W-1:0]   npc_nx;

    fpx_trap_select u_sel (
        .raised   (exc_raised),
        .enables  (stat_in[ENA_LSB +: EXC_W]),
        .decision (dec)
    );

    fpx_status_merge #(.STAT_W(STAT_W)) u_merge (
        .stat_in   (stat_in),
        .decision  (dec),
        .stat_next (stat_nx)
    );

    fpx_pc_step #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_pc (
        .advance  (~dec.trap),
        .pc_cur   (pc_in),
        .pc_nxt   (npc_in),
        .pc_cur_n (pc_nx),
        .pc_nxt_n (npc_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            status_o <= '0;
            pc_o     <= '0;
            npc_o    <= '0;
            trap_o   <= 1'b0;
            ok_o     <= 1'b0;
        end else begin
            trap_o <= upd_valid &  dec.trap;
            ok_o   <= upd_valid & ~dec.trap;
            if (upd_valid) begin
                status_o <= stat_nx;
                pc_o     <= pc_nx;
                npc_o    <= npc_nx;
            end
        end
    end

endmodule

// File: rtl/fpx_recorder_chk.sv
module fpx_recorder_chk
    import fpx_pkg::*;
#(
    parameter int STAT_W  = 32,
    parameter int PC_W    = 64,
    parameter int PC_STEP = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              upd_valid,
    input logic [4:0]        exc_raised,
    input logic [STAT_W-1:0] stat_in,
    input logic [PC_W-1:0]   pc_in,
    input logic [PC_W-1:0]   npc_in,
    input logic [STAT_W-1:0] status_o,
    input logic [PC_W-1:0]   pc_o,
    input logic [PC_W-1:0]   npc_o,
    input logic              trap_o,
    input logic              ok_o
);

    logic [4:0] armed;
    logic       will_trap;

    assign armed     = exc_raised & stat_in[ENA_LSB +: EXC_W];
    assign will_trap = |armed;

    // R2
    trap_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid && will_trap |=> trap_o && !ok_o);

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid && !will_trap |=> ok_o && !trap_o);

    // R3
    single_cause_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid && will_trap |=> $countones(status_o[CUR_LSB +: EXC_W]) == 1
            && (status_o[CUR_LSB +: EXC_W] & ~$past(armed)) == '0);

    // R5
    accrued_hold_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid && will_trap |=> status_o[ACC_LSB +: EXC_W] == $past(stat_in[ACC_LSB +: EXC_W]));

    // R6
    trap_type_chk: assert property (@(posedge clk) disable iff (rst)
        trap_o |-> status_o[TTYP_BIT]);

    // R7
    pc_advance_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid && !will_trap |=> pc_o == $past(npc_in)
            && npc_o == $past(npc_in) + PC_W'(PC_STEP));

    // R7
    trap_pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        upd_valid && will_trap |=> pc_o == $past(pc_in) && npc_o == $past(npc_in));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd_valid |=> $stable(status_o) && $stable(pc_o) && $stable(npc_o) && !trap_o && !ok_o);

endmodule

bind fp_exc_recorder fpx_recorder_chk #(
    .STAT_W  (STAT_W),
    .PC_W    (PC_W),
    .PC_STEP (PC_STEP)
) chk_i (.*);

// File: tb/fp_exc_recorder_tb_top.sv
module fp_exc_recorder_tb_top;

    localparam int STAT_W = 32;
    localparam int PC_W   = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              upd_valid = 1'b0;
    logic [4:0]        exc_raised = '0;
    logic [STAT_W-1:0] stat_in = '0;
    logic [PC_W-1:0]   pc_in = '0;
    logic [PC_W-1:0]   npc_in = '0;
    logic [STAT_W-1:0] status_o;
    logic [PC_W-1:0]   pc_o;
    logic [PC_W-1:0]   npc_o;
    logic              trap_o;
    logic              ok_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fp_exc_recorder #(.STAT_W(STAT_W), .PC_W(PC_W), .PC_STEP(4)) dut_i (
        .clk, .rst, .upd_valid, .exc_raised, .stat_in, .pc_in, .npc_in,
        .status_o, .pc_o, .npc_o, .trap_o, .ok_o
    );

    task automatic cmp(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Apply one strobe at a falling edge, return at the next falling edge with outputs settled
    task automatic strobe(input logic [4:0] rz, input logic [31:0] st,
                          input logic [63:0] pc, input logic [63:0] npc);
        exc_raised = rz;
        stat_in    = st;
        pc_in      = pc;
        npc_in     = npc;
        upd_valid  = 1'b1;
        @(negedge clk);
        upd_valid  = 1'b0;
        exc_raised = 5'h1F;
        stat_in    = 32'hDEAD_BEEF;
        pc_in      = 64'h0BAD;
        npc_in     = 64'h0BAD;
    endtask

    task automatic t_reset;
        @(negedge clk);
        cmp("R1", "status", 64'(status_o), 64'h0);
        cmp("R1", "pc", pc_o, 64'h0);
        cmp("R1", "npc", npc_o, 64'h0);
        cmp("R1", "trap/ok", {62'h0, trap_o, ok_o}, 64'h0);
    endtask

    task automatic t_accrue_passthru;
        // enables off, upper pattern must survive (R10)
        strobe(5'b00101, 32'hF05A_2C10, 64'h1000, 64'h1004);
        cmp("R4", "status", 64'(status_o), 64'hF05A_2CA5);
        cmp("R10", "upper bits", 64'(status_o & 32'hFFFF_BC00), 64'hF05A_2C00);
        cmp("R7", "pc", pc_o, 64'h1004);
        cmp("R7", "npc", npc_o, 64'h1008);
        cmp("R2", "ok/trap", {62'h0, ok_o, trap_o}, 64'h2);
    endtask

    task automatic t_masked_no_trap;
        // only invalid enabled, inexact raised
        strobe(5'b00001, 32'h0800_0000, 64'hFFFF_FFFF_FFFF_FFF8, 64'hFFFF_FFFF_FFFF_FFFC);
        cmp("R2", "trap", 64'(trap_o), 64'h0);
        cmp("R5", "status", 64'(status_o), 64'h0800_0021);
        cmp("R7", "npc wrap", npc_o, 64'h0);
        cmp("R7", "pc", pc_o, 64'hFFFF_FFFF_FFFF_FFFC);
    endtask

    task automatic t_clean_completion;
        strobe(5'b00000, 32'h0F80_03FF, 64'h2000, 64'h2004);
        cmp("R8", "status", 64'(status_o), 64'h0F80_03E0);
        cmp("R8", "pc", pc_o, 64'h2004);
        cmp("R8", "ok", 64'(ok_o), 64'h1);
    endtask

    task automatic t_trap_all;
        strobe(5'b11111, 32'h0F80_0141, 64'h3000, 64'h3004);
        cmp("R3", "status", 64'(status_o), 64'h0F80_4150);
        cmp("R6", "type bit", 64'(status_o[14]), 64'h1);
        cmp("R7", "pc hold", pc_o, 64'h3000);
        cmp("R7", "npc hold", npc_o, 64'h3004);
        cmp("R2", "trap/ok", {62'h0, trap_o, ok_o}, 64'h2);
        @(negedge clk);
        cmp("R2", "trap pulse end", 64'(trap_o), 64'h0);
        cmp("R9", "status held", 64'(status_o), 64'h0F80_4150);
        cmp("R9", "pc held", pc_o, 64'h3000);
    endtask

    task automatic t_trap_priority;
        // raised OF,UF,DZ; enabled UF,DZ -> underflow only
        strobe(5'b01110, 32'h0300_0000, 64'h4000, 64'h4004);
        cmp("R3", "underflow pick", 64'(status_o), 64'h0300_4004);
        // raised DZ,NX; enabled DZ -> divide-by-zero only
        strobe(5'b00011, 32'h0100_0000, 64'h5000, 64'h5004);
        cmp("R3", "divzero pick", 64'(status_o), 64'h0100_4002);
        cmp("R5", "accrued untouched", 64'(status_o[9:5]), 64'h0);
    endtask

    task automatic t_idle;
        repeat (3) @(negedge clk);
        cmp("R9", "status idle", 64'(status_o), 64'h0100_4002);
        cmp("R9", "npc idle", npc_o, 64'h5004);
        cmp("R9", "pulses idle", {62'h0, trap_o, ok_o}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cmp("R1", "status in reset", 64'(status_o), 64'h0);
        rst = 1'b0;
        t_reset();
        t_accrue_passthru();
        t_masked_no_trap();
        t_clean_completion();
        t_trap_all();
        t_trap_priority();
        t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule